// File: doc/BRIEF.md
# Job Request Header Parser and Payload Router

This block sits on a byte stream that carries job requests back to back, with no delimiter between them. Every request opens with an 8-byte header. The header holds a request kind, a job tag, two spare bytes and a 32-bit payload length. The parser captures the header and decodes the kind. It then counts off exactly the number of payload bytes the length field announces. Configuration payloads go to a configuration port. Payloads for user-definable kinds go to a user port, which carries the kind value as a tag. Status and restart requests have their payload consumed and thrown away. A restart request also raises a one-cycle restart pulse.

When a request's payload is finished, or straight after the header if the length is zero, the block sends a short response header. The response echoes the kind and the job tag. The parser then waits for the next header. Every stream edge uses a byte-wide valid/ready handshake. While the selected destination is not ready, the parser holds off its input, so no byte is ever lost or duplicated.

Top module: `jobreq_dispatch`

## Requirements
- R1: After synchronous reset, in_ready is 1, and cfg_valid, usr_valid, rsp_valid and restart_pulse are all 0.
- R2: The header is 8 bytes taken in arrival order. Byte 0 is the kind, byte 1 is the job tag, and bytes 2 and 3 have no effect on any output. Bytes 4 to 7 are the payload length, most significant byte first.
- R3: Kind 0x00 (status) forwards none of its payload bytes on either output port, and its response code byte is 0x01.
- R4: Kind 0x01 (configure) forwards every payload byte, in order and unchanged, on the cfg port only.
- R5: Kinds 0x02 to 0xFE forward every payload byte, in order and unchanged, on the usr port only, with usr_kind equal to the kind.
- R6: Kind 0xFF (restart) raises restart_pulse for exactly one cycle, the cycle after the last header byte is accepted. Its payload is dropped.
- R7: Exactly as many payload bytes as the length field gives are consumed. A length of zero goes straight from the header to the response. After the response, in_ready returns to 1 for the next header.
- R8: Every request produces a 4-byte response: kind, job tag, code (0x01 for status, 0x00 otherwise), then 0x00. in_ready is 0 while the response is pending.
- R9: When the selected payload port is not ready, in_ready is 0. A response byte stays stable while rsp_ready is low. cfg_valid and usr_valid are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request stream byte valid |
| in_ready | output | 1 | Request stream byte accepted |
| in_data | input | 8 | Request stream byte |
| cfg_valid | output | 1 | Configuration payload byte valid |
| cfg_ready | input | 1 | Configuration sink ready |
| cfg_data | output | 8 | Configuration payload byte |
| usr_valid | output | 1 | User payload byte valid |
| usr_ready | input | 1 | User sink ready |
| usr_data | output | 8 | User payload byte |
| usr_kind | output | 8 | Request kind tag for the user payload |
| rsp_valid | output | 1 | Response byte valid |
| rsp_ready | input | 1 | Response sink ready |
| rsp_data | output | 8 | Response byte |
| restart_pulse | output | 1 | One-cycle restart event |

## Verification
The hardest case to reach is a payload byte arriving while its destination stalls, at the same moment the remaining count reaches its last byte. Only then does the move into the response depend on the handshake and not on arrival alone. The stimulus sweeps every kind class against payload lengths 0 to 5, once with all sinks ready and once with pseudo-random ready patterns on all three sinks. This walks the final byte and the response bytes through many stall alignments. A 259-byte configure request proves that the length bytes are weighted most significant first.

// File: rtl/jrd_pkg.sv
`timescale 1ns/1ps
package jrd_pkg;
  typedef enum logic [1:0] {ST_HDR, ST_PAY, ST_RSP} jrd_state_e;
  typedef enum logic [1:0] {RT_DROP, RT_CFG, RT_USR} jrd_route_e;

  localparam logic [7:0] KIND_STATUS  = 8'h00;
  localparam logic [7:0] KIND_CONFIG  = 8'h01;
  localparam logic [7:0] KIND_RESTART = 8'hFF;
endpackage

// File: rtl/jrd_hdr_capture.sv
`timescale 1ns/1ps
module jrd_hdr_capture #(
  parameter int SIZE_BYTES = 4,
  parameter int IDX_W      = 3,
  localparam int SIZE_W    = 8 * SIZE_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [IDX_W-1:0]  idx,
  input  logic [7:0]        data,
  output logic [7:0]        kind,
  output logic [7:0]        job,
  output logic [SIZE_W-1:0] size_next
);
  logic [SIZE_W-1:0] size_q;

  // Length bytes arrive high byte first, so each new byte shifts in at the bottom.
  assign size_next = (size_q << 8) | SIZE_W'(data);

  always_ff @(posedge clk) begin
    if (rst) begin
      kind   <= '0;
      job    <= '0;
      size_q <= '0;
    end else if (take) begin
      if (idx == IDX_W'(0)) kind <= data;
      if (idx == IDX_W'(1)) job  <= data;
      if (idx >= IDX_W'(4)) size_q <= size_next;
    end
  end
endmodule

// File: rtl/jrd_remaining.sv
`timescale 1ns/1ps
module jrd_remaining #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] count_q;

  assign last = (count_q == W'(1));

  always_ff @(posedge clk) begin
    if (rst)       count_q <= '0;
    else if (load) count_q <= load_val;
    else if (dec)  count_q <= count_q - W'(1);
  end
endmodule

// File: rtl/jrd_rsp_framer.sv
`timescale 1ns/1ps
module jrd_rsp_framer #(
  parameter int         RSP_BYTES   = 4,
  parameter logic [7:0] STATUS_CODE = 8'h01,
  localparam int        RIDX_W      = $clog2(RSP_BYTES)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       active,
  input  logic       ready,
  input  logic [7:0] kind,
  input  logic [7:0] job,
  output logic [7:0] data,
  output logic       last
);
  import jrd_pkg::*;
  logic [RIDX_W-1:0] idx_q;

  assign last = (idx_q == RIDX_W'(RSP_BYTES - 1));

  always_comb begin
    case (idx_q)
      RIDX_W'(0): data = kind;
      RIDX_W'(1): data = job;
      RIDX_W'(2): data = (kind == KIND_STATUS) ? STATUS_CODE : 8'h00;
      default:    data = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                  idx_q <= '0;
    else if (active && ready) idx_q <= last ? '0 : idx_q + RIDX_W'(1);
  end
endmodule

// File: rtl/jobreq_dispatch.sv
`timescale 1ns/1ps
module jobreq_dispatch #(
  parameter int SIZE_BYTES = 4,
  parameter int RSP_BYTES  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       cfg_valid,
  input  logic       cfg_ready,
  output logic [7:0] cfg_data,
  output logic       usr_valid,
  input  logic       usr_ready,
  output logic [7:0] usr_data,
  output logic [7:0] usr_kind,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_data,
  output logic       restart_pulse
);
  import jrd_pkg::*;

  localparam int HDR_BYTES = 4 + SIZE_BYTES;
  localparam int HIDX_W    = $clog2(HDR_BYTES);
  localparam int SIZE_W    = 8 * SIZE_BYTES;

  jrd_state_e        st_q;
  jrd_route_e        route_q, route_dec;
  logic [HIDX_W-1:0] hidx_q;
  logic              restart_q;
  logic [7:0]        kind, job;
  logic [SIZE_W-1:0] size_next;
  logic              in_fire, hdr_take, hdr_last, pay_last, rsp_last;

  always_comb begin
    case (st_q)
      ST_HDR:  in_ready = 1'b1;
      ST_PAY:  in_ready = (route_q == RT_CFG) ? cfg_ready :
                          (route_q == RT_USR) ? usr_ready : 1'b1;
      default: in_ready = 1'b0;
    endcase
  end

  assign in_fire  = in_valid && in_ready;
  assign hdr_take = (st_q == ST_HDR) && in_fire;
  assign hdr_last = hdr_take && (hidx_q == HIDX_W'(HDR_BYTES - 1));

  always_comb begin
    if (kind == KIND_STATUS || kind == KIND_RESTART) route_dec = RT_DROP;
    else if (kind == KIND_CONFIG)                    route_dec = RT_CFG;
    else                                             route_dec = RT_USR;
  end

  jrd_hdr_capture #(.SIZE_BYTES(SIZE_BYTES), .IDX_W(HIDX_W)) i_cap (
    .clk(clk), .rst(rst), .take(hdr_take), .idx(hidx_q), .data(in_data),
    .kind(kind), .job(job), .size_next(size_next)
  );

  jrd_remaining #(.W(SIZE_W)) i_rem (
    .clk(clk), .rst(rst), .load(hdr_last), .load_val(size_next),
    .dec((st_q == ST_PAY) && in_fire), .last(pay_last)
  );

  jrd_rsp_framer #(.RSP_BYTES(RSP_BYTES), .STATUS_CODE(8'h01)) i_rsp (
    .clk(clk), .rst(rst), .active(st_q == ST_RSP), .ready(rsp_ready),
    .kind(kind), .job(job), .data(rsp_data), .last(rsp_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_HDR;
      route_q   <= RT_DROP;
      hidx_q    <= '0;
      restart_q <= 1'b0;
    end else begin
      restart_q <= hdr_last && (kind == KIND_RESTART);
      case (st_q)
        ST_HDR: if (hdr_take) begin
          hidx_q <= hdr_last ? '0 : hidx_q + HIDX_W'(1);
          if (hdr_last) begin
            route_q <= route_dec;
            st_q    <= (size_next == '0) ? ST_RSP : ST_PAY;
          end
        end
        ST_PAY: if (in_fire && pay_last) st_q <= ST_RSP;
        default: if (rsp_ready && rsp_last) st_q <= ST_HDR;
      endcase
    end
  end

  assign cfg_valid     = (st_q == ST_PAY) && (route_q == RT_CFG) && in_valid;
  assign usr_valid     = (st_q == ST_PAY) && (route_q == RT_USR) && in_valid;
  assign cfg_data      = in_data;
  assign usr_data      = in_data;
  assign usr_kind      = kind;
  assign rsp_valid     = (st_q == ST_RSP);
  assign restart_pulse = restart_q;
endmodule

// File: rtl/jrd_checker.sv
`timescale 1ns/1ps
module jrd_checker (
  input logic       clk,
  input logic       rst,
  input logic       in_ready,
  input logic       cfg_valid,
  input logic       cfg_ready,
  input logic       usr_valid,
  input logic [7:0] usr_kind,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data,
  input logic       restart_pulse
);
  p_single_route_r9: assert property (@(posedge clk) disable iff (rst)
    !(cfg_valid && usr_valid));

  p_cfg_stall_r9: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && !cfg_ready) |-> !in_ready);

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  p_restart_once_r6: assert property (@(posedge clk) disable iff (rst)
    restart_pulse |=> !restart_pulse);

  p_user_kind_r5: assert property (@(posedge clk) disable iff (rst)
    usr_valid |-> (usr_kind != 8'h00 && usr_kind != 8'h01 && usr_kind != 8'hFF));

  p_rsp_blocks_input_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !in_ready);
endmodule

bind jobreq_dispatch jrd_checker i_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .cfg_valid(cfg_valid),
  .cfg_ready(cfg_ready), .usr_valid(usr_valid), .usr_kind(usr_kind),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .restart_pulse(restart_pulse)
);

// File: tb/test_jobreq_dispatch.sv
`timescale 1ns/1ps
module test_jobreq_dispatch;
  logic       clk = 1'b0, rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       cfg_ready = 1'b1, usr_ready = 1'b1, rsp_ready = 1'b1;
  logic       in_ready, cfg_valid, usr_valid, rsp_valid, restart_pulse;
  logic [7:0] cfg_data, usr_data, usr_kind, rsp_data;

  int n_cmp = 0, n_bad = 0;
  bit bp_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [7:0] cfg_log [512];
  logic [7:0] usr_log [512];
  logic [7:0] kind_log [512];
  logic [7:0] rsp_log [8];
  int cfg_n = 0, usr_n = 0, rsp_n = 0, rst_n = 0;

  jobreq_dispatch i_jobreq_dispatch (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_data(cfg_data),
    .usr_valid(usr_valid), .usr_ready(usr_ready), .usr_data(usr_data), .usr_kind(usr_kind),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .restart_pulse(restart_pulse)
  );

  always #2 clk = ~clk;

  function automatic void check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endfunction

  // Sink readiness patterns, changed away from the active edge.
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    cfg_ready = bp_en ? lfsr[0] : 1'b1;
    usr_ready = bp_en ? lfsr[3] : 1'b1;
    rsp_ready = bp_en ? lfsr[7] : 1'b1;
  end

  // Monitors: a handshake seen at a falling edge completes at the next rising edge.
  always @(negedge clk) if (!rst) begin
    if (cfg_valid && cfg_ready) begin
      if (cfg_n < 512) cfg_log[cfg_n] = cfg_data;
      cfg_n++;
    end
    if (usr_valid && usr_ready) begin
      if (usr_n < 512) begin usr_log[usr_n] = usr_data; kind_log[usr_n] = usr_kind; end
      usr_n++;
    end
    if (rsp_valid && rsp_ready) begin
      if (rsp_n < 8) rsp_log[rsp_n] = rsp_data;
      rsp_n++;
    end
    if (restart_pulse) rst_n++;
    if (cfg_valid && !cfg_ready) check(!in_ready, "R9 stall cfg", in_ready, 0);
    if (usr_valid && !usr_ready) check(!in_ready, "R9 stall usr", in_ready, 0);
    if (rsp_valid) check(!in_ready, "R8 input held during response", in_ready, 0);
  end

  task automatic push(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic run_req(input logic [7:0] t, input logic [7:0] job, input logic [31:0] size);
    string tag;
    int exp_cfg, exp_usr, bad_i;
    tag = (t == 8'h00) ? "R3" : (t == 8'h01) ? "R4" : (t == 8'hFF) ? "R6" : "R5";
    cfg_n = 0; usr_n = 0; rsp_n = 0; rst_n = 0;
    push(t); push(job); push(8'hA5); push(~job);  // bytes 2,3 carry junk (R2)
    push(size[31:24]); push(size[23:16]); push(size[15:8]); push(size[7:0]);
    for (int i = 0; i < int'(size); i++) push(8'(job * 7 + i));
    while (rsp_n < 4) @(negedge clk);
    repeat (2) @(negedge clk);
    exp_cfg = (t == 8'h01) ? int'(size) : 0;
    exp_usr = (t > 8'h01 && t < 8'hFF) ? int'(size) : 0;
    check(cfg_n == exp_cfg, {tag, " cfg byte count"}, cfg_n, exp_cfg);
    check(usr_n == exp_usr, {tag, " usr byte count"}, usr_n, exp_usr);
    bad_i = -1;
    for (int i = 0; i < exp_cfg && i < 512; i++)
      if (bad_i < 0 && cfg_log[i] != 8'(job * 7 + i)) bad_i = i;
    for (int i = 0; i < exp_usr && i < 512; i++)
      if (bad_i < 0 && (usr_log[i] != 8'(job * 7 + i) || kind_log[i] != t)) bad_i = i;
    check(bad_i < 0, {tag, " payload content/kind, first bad index"}, bad_i, -1);
    check(rst_n == ((t == 8'hFF) ? 1 : 0), "R6 restart pulse count", rst_n, (t == 8'hFF) ? 1 : 0);
    check(rsp_n == 4, "R8 response length", rsp_n, 4);
    check(rsp_log[0] == t,   "R8 response kind", rsp_log[0], t);
    check(rsp_log[1] == job, "R8 response job tag", rsp_log[1], job);
    check(rsp_log[2] == ((t == 8'h00) ? 8'h01 : 8'h00), "R8 response code",
          rsp_log[2], (t == 8'h00) ? 1 : 0);
    check(rsp_log[3] == 8'h00, "R8 response tail", rsp_log[3], 0);
    check(in_ready == 1'b1, "R7 back to header wait", in_ready, 1);
    if (size == 0) check(cfg_n + usr_n == 0, "R7 zero length forwards nothing", cfg_n + usr_n, 0);
    @(posedge clk); #1;
  endtask

  initial begin
    logic [7:0] kinds [6];
    logic [7:0] job;
    kinds[0] = 8'h00; kinds[1] = 8'h01; kinds[2] = 8'h02;
    kinds[3] = 8'h7F; kinds[4] = 8'hFE; kinds[5] = 8'hFF;
    job = 8'h10;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 reset in_ready", in_ready, 1);
    check({cfg_valid, usr_valid, rsp_valid, restart_pulse} == 4'b0, "R1 reset outputs idle",
          {cfg_valid, usr_valid, rsp_valid, restart_pulse}, 0);
    @(posedge clk); #1;
    for (int b = 0; b < 2; b++) begin
      bp_en = (b == 1);
      for (int k = 0; k < 6; k++)
        for (int s = 0; s <= 5; s++) begin
          run_req(kinds[k], job, 32'(s));
          job = job + 8'd13;
        end
    end
    // R2: 259 = 0x00000103 proves high-byte-first weighting of the length.
    run_req(8'h01, 8'h5C, 32'h0000_0103);
    check(cfg_n == 259, "R2 length byte order", cfg_n, 259);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule